// File: doc/BRIEF.md
# Seven-Level Bus Interrupt Requester

This block raises one interrupt request on a backplane that carries seven prioritized request lines. Software writes a 3-bit level field. The value zero keeps every line released. A value from 1 to 7 pulls low exactly the request line with that number. The request lines are active-low, open-collector enables, so a line is driven only while it is the selected one.

A pending request ends in one of four ways. An interrupt acknowledge cycle addressed to this module clears the field. Software can write zero at any time. A module reset clears it, and so does a soft-reset bit held in a separate control register. When a clear and a software write fall in the same cycle, the clear wins. The field can be read back at any time, so software can poll whether its request has been serviced.

The module-ID bits that share the register byte are decoded by a neighbouring block. Only the 3-bit level field reaches this one.

Top module: `irq_requester`

## Requirements
- R1: While reset is active and on the first cycle after it, the level readback is 0 and all seven request outputs are high (released).
- R2: A write with a level n from 1 to 7, with no clear in the same cycle, shows n on the readback after the next rising clock edge. From that edge, request output bit n-1 is low and all other bits are high.
- R3: A write of level 0 releases every request line after the next rising clock edge.
- R4: An acknowledge pulse sampled at a rising edge sets the field to 0 and releases all lines from that edge.
- R5: A soft-reset input sampled high at a rising edge sets the field to 0, and the field stays 0 for as long as soft-reset is held.
- R6: When a write and an acknowledge or soft-reset are sampled at the same edge, the field becomes 0 and the written level is discarded.
- R7: With no write and no clear, the field and the request lines keep their value across any number of cycles.
- R8: At most one request line is low at any time. A new nonzero write moves the request to the new line and does not add a second line.
- R9: The request outputs always match the readback: output bit i is low if and only if the readback equals i+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous module reset, active low |
| wr_en | input | 1 | Write strobe for the level field |
| wr_level | input | 3 | Level to load (0 means no request) |
| iack | input | 1 | Acknowledge cycle addressed to this module, one-cycle pulse |
| soft_rst | input | 1 | Soft-reset bit from the control register |
| irq_n | output | 7 | Active-low request enables; bit i drives line i+1 |
| level_rd | output | 3 | Current level field for readback |

## Verification
On every cycle the assertions check four things. They check that no more than one request line is low. They check that the lines always agree with the readback. They check that a clear sampled at an edge empties the field, and that an idle cycle leaves the field unchanged. Only the bench scenarios show the whole path. In those runs each of the seven levels is written in turn. A request moves between lines without overlap. A write and a clear collide in the same cycle. Reset arrives while a request is pending, and soft-reset is held across several attempted writes.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;

  // What the level register does on the coming clock edge.
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_LOAD  = 2'd1,
    UPD_CLEAR = 2'd2
  } upd_e;

  // A clear always takes precedence over a software load.
  function automatic upd_e pick_update(logic wr, logic clr);
    if (clr)     return UPD_CLEAR;
    else if (wr) return UPD_LOAD;
    else         return UPD_HOLD;
  endfunction

endpackage

// File: rtl/irq_level_reg.sv
module irq_level_reg
  import irq_level_pkg::*;
#(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  upd_e             upd,
  input  logic [LVL_W-1:0] load_val,
  output logic [LVL_W-1:0] level_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
    end else begin
      unique case (upd)
        UPD_LOAD:  level_q <= load_val;
        UPD_CLEAR: level_q <= '0;
        default:   level_q <= level_q;
      endcase
    end
  end

endmodule

// File: rtl/irq_line_decode.sv
module irq_line_decode #(
  parameter int unsigned NUM_LINES = 7,
  parameter int unsigned LVL_W     = 3
) (
  input  logic [LVL_W-1:0]     level,
  output logic [NUM_LINES-1:0] line_n
);

  // Line k+1 is pulled low only when the level selects it.
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    localparam logic [LVL_W-1:0] SEL = LVL_W'(k + 1);
    assign line_n[k] = (level != SEL);
  end

endmodule

// File: rtl/irq_requester.sv
module irq_requester
  import irq_level_pkg::*;
#(
  parameter int unsigned NUM_LINES = 7,
  localparam int unsigned LVL_W    = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [LVL_W-1:0]     wr_level,
  input  logic                 iack,
  input  logic                 soft_rst,
  output logic [NUM_LINES-1:0] irq_n,
  output logic [LVL_W-1:0]     level_rd
);

  logic             clear_evt;
  upd_e             upd;
  logic [LVL_W-1:0] level_q;

  assign clear_evt = iack | soft_rst;
  assign upd       = pick_update(wr_en, clear_evt);

  irq_level_reg #(.LVL_W(LVL_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (upd),
    .load_val (wr_level),
    .level_q  (level_q)
  );

  irq_line_decode #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W)) u_dec (
    .level  (level_q),
    .line_n (irq_n)
  );

  assign level_rd = level_q;

endmodule

// File: rtl/irq_requester_checker.sv
module irq_requester_checker #(
  parameter int unsigned NUM_LINES = 7,
  parameter int unsigned LVL_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [LVL_W-1:0]     wr_level,
  input logic                 iack,
  input logic                 soft_rst,
  input logic [NUM_LINES-1:0] irq_n,
  input logic [LVL_W-1:0]     level_rd
);

  assert_one_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~irq_n));

  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (level_rd == '0) |-> (&irq_n));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> (level_rd == '0));

  assert_srst_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (level_rd == '0));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !iack && !soft_rst) |=> (level_rd == $past(wr_level)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !iack && !soft_rst) |=> ($stable(level_rd) && $stable(irq_n)));

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_match
    assert_line_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n[k]) == (level_rd == LVL_W'(k + 1)));
  end

endmodule

bind irq_requester irq_requester_checker #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_level (wr_level),
  .iack     (iack),
  .soft_rst (soft_rst),
  .irq_n    (irq_n),
  .level_rd (level_rd)
);

// File: tb/test_irq_requester.sv
`timescale 1ns/1ps
module test_irq_requester;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_level = '0;
  logic       iack = 1'b0;
  logic       soft_rst = 1'b0;
  logic [6:0] irq_n;
  logic [2:0] level_rd;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_requester i_irq_requester (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_level(wr_level),
    .iack(iack), .soft_rst(soft_rst), .irq_n(irq_n), .level_rd(level_rd)
  );

  // Vector: {req[3:0], wr, lvl[2:0], iack, srst, exp[2:0]}
  localparam int NV = 16;
  localparam logic [12:0] VEC [NV] = '{
    {4'd2, 1'b1, 3'd1, 1'b0, 1'b0, 3'd1},  // R2 level 1
    {4'd8, 1'b1, 3'd2, 1'b0, 1'b0, 3'd2},  // R8 moves to line 2
    {4'd2, 1'b1, 3'd3, 1'b0, 1'b0, 3'd3},  // R2
    {4'd2, 1'b1, 3'd4, 1'b0, 1'b0, 3'd4},  // R2
    {4'd2, 1'b1, 3'd5, 1'b0, 1'b0, 3'd5},  // R2
    {4'd2, 1'b1, 3'd6, 1'b0, 1'b0, 3'd6},  // R2
    {4'd2, 1'b1, 3'd7, 1'b0, 1'b0, 3'd7},  // R2 level 7
    {4'd7, 1'b0, 3'd2, 1'b0, 1'b0, 3'd7},  // R7 idle hold
    {4'd4, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0},  // R4 acknowledge
    {4'd2, 1'b1, 3'd5, 1'b0, 1'b0, 3'd5},  // R2
    {4'd3, 1'b1, 3'd0, 1'b0, 1'b0, 3'd0},  // R3 write zero
    {4'd2, 1'b1, 3'd3, 1'b0, 1'b0, 3'd3},  // R2
    {4'd6, 1'b1, 3'd6, 1'b1, 1'b0, 3'd0},  // R6 ack beats write
    {4'd2, 1'b1, 3'd2, 1'b0, 1'b0, 3'd2},  // R2
    {4'd5, 1'b0, 3'd0, 1'b0, 1'b1, 3'd0},  // R5 soft reset
    {4'd6, 1'b1, 3'd4, 1'b0, 1'b1, 3'd0}   // R6 soft reset beats write
  };

  function automatic logic [6:0] expect_lines(logic [2:0] lvl);
    logic [6:0] r = 7'h7f;
    if (lvl != 3'd0) r[lvl - 3'd1] = 1'b0;
    return r;
  endfunction

  task automatic check(int req, logic [2:0] exp_lvl);
    checks++;
    if (level_rd !== exp_lvl || irq_n !== expect_lines(exp_lvl)) begin
      errors++;
      $display("FAIL R%0d: level=%0d irq_n=%b expected level=%0d irq_n=%b",
               req, level_rd, irq_n, exp_lvl, expect_lines(exp_lvl));
    end
  endtask

  task automatic step(logic w, logic [2:0] l, logic a, logic s);
    @(negedge clk);
    wr_en = w; wr_level = l; iack = a; soft_rst = s;
    @(posedge clk);
    #1;
    wr_en = 1'b0; iack = 1'b0; soft_rst = 1'b0;
  endtask

  initial begin : watchdog
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12;
    check(1, 3'd0);            // R1 during reset
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check(1, 3'd0);            // R1 after release

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8], VEC[i][7:5], VEC[i][4], VEC[i][3]);
      check(int'(VEC[i][12:9]), VEC[i][2:0]);
    end

    // R7: long idle keeps a pending request
    step(1'b1, 3'd6, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) step(1'b0, 3'd1, 1'b0, 1'b0);
    check(7, 3'd6);

    // R5: soft reset held across several write attempts
    @(negedge clk) soft_rst = 1'b1;
    for (int k = 1; k < 4; k++) begin
      @(negedge clk) begin wr_en = 1'b1; wr_level = 3'(k); end
      @(posedge clk); #1;
      check(5, 3'd0);
    end
    @(negedge clk) begin soft_rst = 1'b0; wr_en = 1'b0; end

    // R1: reset while a request is pending
    step(1'b1, 3'd7, 1'b0, 1'b0);
    check(2, 3'd7);
    @(negedge clk) rst_n = 1'b0;
    #1 check(1, 3'd0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check(1, 3'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule